// File: doc/BRIEF.md
# Byte-Lane Register Window Decoder

This block sits between a host access port and three 32-bit register groups inside a storage controller: a bank of sixteen SCSI core registers, a bank of eight DMA channel registers and one bus-and-control register. The host sees a 128-byte little-endian window and may access 1, 2, 3 or 4 bytes at any byte offset. Every downstream access is a full 32-bit word at a word-aligned address.

A narrow or misaligned write becomes a read-modify-write merge. In the request cycle the decoder takes the current word from the target group through that group's asynchronous read port. It replaces only the addressed byte lanes and issues a single full-word write. No read strobe is raised for this fetch, so registers whose reads have side effects are left undisturbed. A read selects the word and shifts it right by the byte offset. It masks the result to the requested size and returns it one cycle later with a valid pulse.

Top module: `bl_win_top`

## Requirements
- R1: After reset `rvalid_o` is 0 and `rdata_o` is 0.
- R2: Word addresses 0x00 to 0x3C select the core group at index `addr_i[5:2]`. An aligned 4-byte write there raises only `core_we_o`, with `core_wdata_o` equal to `wdata_i`.
- R3: Word addresses 0x40 to 0x5C select the DMA group at index `(addr_i - 0x40) >> 2`. A write there raises only `dma_we_o`.
- R4: The control register is reached only at word address 0x70, meaning byte addresses 0x70 to 0x73. For every other word at or above 0x60, writes raise no write strobe and reads return 0.
- R5: `size_i` holds the byte count minus one, and `addr_i[1:0]` is the byte offset. On a write, lane b (bits 8b+7:8b) takes `wdata_i` byte (b - offset) when offset <= b <= offset + size. Every other lane keeps the target's current value. The merged word is written at the word-aligned address.
- R6: When a write runs past byte lane 3, the bytes beyond lane 3 are dropped. Nothing is written to the next word.
- R7: Read data equals the selected word shifted right by 8 × offset, with only the low 8 × (size + 1) bits kept. Bytes past lane 3 read as 0.
- R8: A read request produces `rvalid_o` high for exactly one cycle, in the cycle after the request. Writes and idle cycles leave `rvalid_o` low.
- R9: A read raises exactly the read strobe of the selected group during the request cycle. No read strobe rises on a write, including the merge fetch.
- R10: At most one group write strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 7 | Byte address in the window |
| size_i | input | 2 | Byte count minus one |
| wdata_i | input | 32 | Write data, low bytes used |
| rdata_o | output | 32 | Aligned read data |
| rvalid_o | output | 1 | Read data valid |
| core_idx_o | output | 4 | Core group word index |
| core_we_o | output | 1 | Core group write strobe |
| core_re_o | output | 1 | Core group read strobe |
| core_wdata_o | output | 32 | Core group write word |
| core_rdata_i | input | 32 | Core group word at core_idx_o (asynchronous) |
| dma_idx_o | output | 3 | DMA group word index |
| dma_we_o | output | 1 | DMA group write strobe |
| dma_re_o | output | 1 | DMA group read strobe |
| dma_wdata_o | output | 32 | DMA group write word |
| dma_rdata_i | input | 32 | DMA group word at dma_idx_o (asynchronous) |
| ctl_we_o | output | 1 | Control register write strobe |
| ctl_re_o | output | 1 | Control register read strobe |
| ctl_wdata_o | output | 32 | Control register write word |
| ctl_rdata_i | input | 32 | Control register value |

## Verification
The hardest case to reach is a misaligned write that crosses the word boundary, landing in a word whose untouched lanes must survive. This is worst in the 0x60 to 0x6F gap, where the fetch comes from the control register but no write may follow. The bench preloads every word of a register image with distinct bytes. It then sweeps all 128 byte addresses against all four sizes, comparing the full image after each write, so a stray or truncated lane shows up at once. A second sweep reads every address and size back through the port.

// File: rtl/bl_win_pkg.sv
package bl_win_pkg;
  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_CORE = 2'd1,
    GRP_DMA  = 2'd2,
    GRP_CTL  = 2'd3
  } grp_e;
endpackage

// File: rtl/bl_win_decode.sv
module bl_win_decode
  import bl_win_pkg::*;
#(
  parameter int unsigned AW       = 7,
  parameter int unsigned NB       = 4,
  parameter int unsigned CORE_IW  = 4,
  parameter int unsigned DMA_IW   = 3,
  parameter int unsigned CTL_ADDR = 'h70
) (
  input  logic [AW-1:0]      addr_i,
  output grp_e               acc_grp_o,
  output grp_e               fetch_grp_o,
  output logic [CORE_IW-1:0] core_idx_o,
  output logic [DMA_IW-1:0]  dma_idx_o
);
  localparam int unsigned OW = $clog2(NB);
  localparam logic [AW-1:0] DMA_BASE  = AW'(NB << CORE_IW);
  localparam logic [AW-1:0] DMA_END   = AW'((NB << CORE_IW) + (NB << DMA_IW));
  localparam logic [AW-1:0] CTL_A     = AW'(CTL_ADDR);
  localparam logic [AW-1:0] FETCH_END = AW'(CTL_ADDR + NB);

  logic [AW-1:0] wa;
  logic [AW-1:0] dma_off;

  assign wa      = {addr_i[AW-1:OW], {OW{1'b0}}};
  assign dma_off = wa - DMA_BASE;

  assign core_idx_o = wa[CORE_IW+OW-1:OW];
  assign dma_idx_o  = dma_off[DMA_IW+OW-1:OW];

  always_comb begin
    if (wa < DMA_BASE)      acc_grp_o = GRP_CORE;
    else if (wa < DMA_END)  acc_grp_o = GRP_DMA;
    else if (wa == CTL_A)   acc_grp_o = GRP_CTL;
    else                    acc_grp_o = GRP_NONE;
  end

  // merge source: the whole upper gap up to the control word fetches control
  always_comb begin
    if (wa < DMA_BASE)        fetch_grp_o = GRP_CORE;
    else if (wa < DMA_END)    fetch_grp_o = GRP_DMA;
    else if (wa < FETCH_END)  fetch_grp_o = GRP_CTL;
    else                      fetch_grp_o = GRP_NONE;
  end
endmodule

// File: rtl/bl_win_merge.sv
module bl_win_merge #(
  parameter int unsigned DW = 32,
  parameter int unsigned NB = DW / 8,
  parameter int unsigned OW = $clog2(NB)
) (
  input  logic [DW-1:0] cur_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [OW-1:0] off_i,
  input  logic [OW-1:0] size_i,
  output logic [DW-1:0] word_o
);
  logic [DW-1:0] shifted;
  logic [OW:0]   last;

  assign shifted = wdata_i << {off_i, 3'b000};
  assign last    = {1'b0, off_i} + {1'b0, size_i};

  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam logic [OW:0] LB = (OW+1)'(b);
    logic sel;
    assign sel = (LB >= {1'b0, off_i}) && (LB <= last);
    assign word_o[8*b +: 8] = sel ? shifted[8*b +: 8] : cur_i[8*b +: 8];
  end
endmodule

// File: rtl/bl_win_ralign.sv
module bl_win_ralign #(
  parameter int unsigned DW = 32,
  parameter int unsigned NB = DW / 8,
  parameter int unsigned OW = $clog2(NB)
) (
  input  logic [DW-1:0] word_i,
  input  logic [OW-1:0] off_i,
  input  logic [OW-1:0] size_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] shifted;

  assign shifted = word_i >> {off_i, 3'b000};

  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam logic [OW-1:0] LB = OW'(b);
    assign data_o[8*b +: 8] = (LB <= size_i) ? shifted[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/bl_win_top.sv
module bl_win_top
  import bl_win_pkg::*;
#(
  parameter int unsigned AW       = 7,
  parameter int unsigned DW       = 32,
  parameter int unsigned CORE_IW  = 4,
  parameter int unsigned DMA_IW   = 3,
  parameter int unsigned CTL_ADDR = 'h70,
  localparam int unsigned NB      = DW / 8,
  localparam int unsigned OW      = $clog2(NB)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [OW-1:0]      size_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               rvalid_o,
  output logic [CORE_IW-1:0] core_idx_o,
  output logic               core_we_o,
  output logic               core_re_o,
  output logic [DW-1:0]      core_wdata_o,
  input  logic [DW-1:0]      core_rdata_i,
  output logic [DMA_IW-1:0]  dma_idx_o,
  output logic               dma_we_o,
  output logic               dma_re_o,
  output logic [DW-1:0]      dma_wdata_o,
  input  logic [DW-1:0]      dma_rdata_i,
  output logic               ctl_we_o,
  output logic               ctl_re_o,
  output logic [DW-1:0]      ctl_wdata_o,
  input  logic [DW-1:0]      ctl_rdata_i
);
  grp_e          acc_grp, fetch_grp;
  logic [OW-1:0] off;
  logic [DW-1:0] cur_word, merged, sel_word, aligned;
  logic          wr, rd;

  assign off = addr_i[OW-1:0];
  assign wr  = req_i && we_i;
  assign rd  = req_i && !we_i;

  bl_win_decode #(
    .AW(AW), .NB(NB), .CORE_IW(CORE_IW), .DMA_IW(DMA_IW), .CTL_ADDR(CTL_ADDR)
  ) u_dec (
    .addr_i      (addr_i),
    .acc_grp_o   (acc_grp),
    .fetch_grp_o (fetch_grp),
    .core_idx_o  (core_idx_o),
    .dma_idx_o   (dma_idx_o)
  );

  always_comb begin
    unique case (fetch_grp)
      GRP_CORE: cur_word = core_rdata_i;
      GRP_DMA:  cur_word = dma_rdata_i;
      GRP_CTL:  cur_word = ctl_rdata_i;
      default:  cur_word = '0;
    endcase
  end

  always_comb begin
    unique case (acc_grp)
      GRP_CORE: sel_word = core_rdata_i;
      GRP_DMA:  sel_word = dma_rdata_i;
      GRP_CTL:  sel_word = ctl_rdata_i;
      default:  sel_word = '0;
    endcase
  end

  // full aligned writes pass through the merge with every lane selected
  bl_win_merge #(.DW(DW), .NB(NB), .OW(OW)) u_merge (
    .cur_i   (cur_word),
    .wdata_i (wdata_i),
    .off_i   (off),
    .size_i  (size_i),
    .word_o  (merged)
  );

  bl_win_ralign #(.DW(DW), .NB(NB), .OW(OW)) u_ralign (
    .word_i (sel_word),
    .off_i  (off),
    .size_i (size_i),
    .data_o (aligned)
  );

  assign core_we_o = wr && (acc_grp == GRP_CORE);
  assign dma_we_o  = wr && (acc_grp == GRP_DMA);
  assign ctl_we_o  = wr && (acc_grp == GRP_CTL);
  assign core_re_o = rd && (acc_grp == GRP_CORE);
  assign dma_re_o  = rd && (acc_grp == GRP_DMA);
  assign ctl_re_o  = rd && (acc_grp == GRP_CTL);

  assign core_wdata_o = merged;
  assign dma_wdata_o  = merged;
  assign ctl_wdata_o  = merged;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= aligned;
    end
  end
endmodule

// File: rtl/bl_win_chk.sv
module bl_win_chk #(
  parameter int unsigned AW       = 7,
  parameter int unsigned DW       = 32,
  parameter int unsigned CORE_IW  = 4,
  parameter int unsigned CTL_ADDR = 'h70,
  parameter int unsigned OW       = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [OW-1:0] size_i,
  input logic [DW-1:0] wdata_i,
  input logic          rvalid_o,
  input logic          core_we_o,
  input logic          core_re_o,
  input logic [DW-1:0] core_wdata_o,
  input logic [DW-1:0] core_rdata_i,
  input logic          dma_we_o,
  input logic          dma_re_o,
  input logic          ctl_we_o,
  input logic          ctl_re_o
);
  localparam logic [AW-OW-1:0] CTL_W = (AW-OW)'(CTL_ADDR >> OW);
  logic in_core;
  assign in_core = (addr_i[AW-1:CORE_IW+OW] == '0);

  // R10
  one_wr_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({core_we_o, dma_we_o, ctl_we_o}));

  // R8
  rvalid_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  // R8
  rvalid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  // R9
  no_re_on_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |-> !(core_re_o || dma_re_o || ctl_re_o));

  // R4
  ctl_word_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_o |-> (addr_i[AW-1:OW] == CTL_W));

  // R2
  core_full_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && in_core && (size_i == '1) && (addr_i[OW-1:0] == '0))
      |-> (core_we_o && (core_wdata_o == wdata_i)));

  // R5
  core_byte_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && in_core && (size_i == '0) && (addr_i[OW-1:0] == '0))
      |-> ((core_wdata_o[DW-1:8] == core_rdata_i[DW-1:8]) &&
           (core_wdata_o[7:0] == wdata_i[7:0])));
endmodule

bind bl_win_top bl_win_chk #(
  .AW(AW), .DW(DW), .CORE_IW(CORE_IW), .CTL_ADDR(CTL_ADDR), .OW(OW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .size_i       (size_i),
  .wdata_i      (wdata_i),
  .rvalid_o     (rvalid_o),
  .core_we_o    (core_we_o),
  .core_re_o    (core_re_o),
  .core_wdata_o (core_wdata_o),
  .core_rdata_i (core_rdata_i),
  .dma_we_o     (dma_we_o),
  .dma_re_o     (dma_re_o),
  .ctl_we_o     (ctl_we_o),
  .ctl_re_o     (ctl_re_o)
);

// File: tb/bl_win_top_tb_top.sv
module bl_win_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic [3:0]  core_idx_o;
  logic        core_we_o, core_re_o;
  logic [31:0] core_wdata_o, core_rdata_i;
  logic [2:0]  dma_idx_o;
  logic        dma_we_o, dma_re_o;
  logic [31:0] dma_wdata_o, dma_rdata_i;
  logic        ctl_we_o, ctl_re_o;
  logic [31:0] ctl_wdata_o, ctl_rdata_i;

  int n_chk = 0;
  int n_fail = 0;

  // register image: word w of the window lives at img[w]
  logic [31:0] img [32];
  logic [31:0] exp_img [32];

  always #10 clk_i = ~clk_i;

  bl_win_top dut_i (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .size_i, .wdata_i,
    .rdata_o, .rvalid_o,
    .core_idx_o, .core_we_o, .core_re_o, .core_wdata_o, .core_rdata_i,
    .dma_idx_o, .dma_we_o, .dma_re_o, .dma_wdata_o, .dma_rdata_i,
    .ctl_we_o, .ctl_re_o, .ctl_wdata_o, .ctl_rdata_i
  );

  assign core_rdata_i = img[core_idx_o];
  assign dma_rdata_i  = img[16 + int'(dma_idx_o)];
  assign ctl_rdata_i  = img[28];

  always @(posedge clk_i) begin
    if (core_we_o) img[core_idx_o] <= core_wdata_o;
    if (dma_we_o)  img[16 + int'(dma_idx_o)] <= dma_wdata_o;
    if (ctl_we_o)  img[28] <= ctl_wdata_o;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_merge(logic [31:0] cur, logic [31:0] d, int off, int sz);
    logic [31:0] r = cur;
    for (int b = 0; b < 4; b++)
      if (b >= off && b <= off + sz) r[8*b +: 8] = d[8*(b-off) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] f_align(logic [31:0] w, int off, int sz);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++)
      if (b <= sz && b + off <= 3) r[8*b +: 8] = w[8*(b+off) +: 8];
    return r;
  endfunction

  function automatic bit f_mapped(int wa);
    return (wa < 'h60) || (wa == 'h70);
  endfunction

  function automatic logic [2:0] f_grp(int wa);
    if (wa < 'h40) return 3'b100;
    if (wa < 'h60) return 3'b010;
    if (wa == 'h70) return 3'b001;
    return 3'b000;
  endfunction

  function automatic string f_tag(int wa);
    if (wa < 'h40) return "R2";
    if (wa < 'h60) return "R3";
    return "R4";
  endfunction

  task automatic do_write(input int a, input int s, input logic [31:0] d);
    int wa = a & ~3;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 7'(a); size_i = 2'(s); wdata_i = d;
    #1;
    chk({core_we_o, dma_we_o, ctl_we_o} == f_grp(wa), f_tag(wa),
        32'({core_we_o, dma_we_o, ctl_we_o}), 32'(f_grp(wa)));
    chk($countones({core_we_o, dma_we_o, ctl_we_o}) <= 1, "R10",
        32'({core_we_o, dma_we_o, ctl_we_o}), 32'd0);
    chk({core_re_o, dma_re_o, ctl_re_o} == 3'b000, "R9",
        32'({core_re_o, dma_re_o, ctl_re_o}), 32'd0);
    if (wa < 'h40) chk(core_idx_o == 4'(wa >> 2), "R2", 32'(core_idx_o), 32'(wa >> 2));
    else if (wa < 'h60) chk(dma_idx_o == 3'((wa - 'h40) >> 2), "R3", 32'(dma_idx_o), 32'((wa - 'h40) >> 2));
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    chk(rvalid_o == 1'b0, "R8", 32'(rvalid_o), 32'd0);
    if (f_mapped(wa)) exp_img[wa >> 2] = f_merge(exp_img[wa >> 2], d, a & 3, s);
    for (int w = 0; w < 32; w++)
      chk(img[w] === exp_img[w], ((a & 3) + s > 3) ? "R6" : "R5", img[w], exp_img[w]);
  endtask

  task automatic do_read(input int a, input int s);
    int wa = a & ~3;
    logic [31:0] e;
    e = f_mapped(wa) ? f_align(exp_img[wa >> 2], a & 3, s) : 32'd0;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = 7'(a); size_i = 2'(s);
    #1;
    chk({core_re_o, dma_re_o, ctl_re_o} == f_grp(wa), "R9",
        32'({core_re_o, dma_re_o, ctl_re_o}), 32'(f_grp(wa)));
    @(negedge clk_i);
    req_i = 1'b0;
    chk(rvalid_o == 1'b1, "R8", 32'(rvalid_o), 32'd1);
    chk(rdata_o === e, f_mapped(wa) ? "R7" : "R4", rdata_o, e);
    @(negedge clk_i);
    chk(rvalid_o == 1'b0, "R8", 32'(rvalid_o), 32'd0);
  endtask

  initial begin
    for (int w = 0; w < 32; w++) begin
      img[w] = 32'h0F1E2D3C ^ (32'(w) * 32'h01010101) ^ 32'h80402010;
      exp_img[w] = img[w];
    end
    repeat (3) @(negedge clk_i);
    chk(rvalid_o == 1'b0, "R1", 32'(rvalid_o), 32'd0);
    chk(rdata_o == 32'd0, "R1", rdata_o, 32'd0);
    rst_ni = 1'b1;
    // full-word writes across the whole window
    for (int wa = 0; wa < 128; wa += 4)
      do_write(wa, 3, 32'hA0B0C0D0 ^ 32'(wa));
    // every byte address and size
    for (int a = 0; a < 128; a++)
      for (int s = 0; s < 4; s++)
        do_write(a, s, {8'(a), 8'(s + 8'h51), 8'(a ^ 8'h3C), 8'(s + 8'hE0)});
    for (int a = 0; a < 128; a++)
      for (int s = 0; s < 4; s++)
        do_read(a, s);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule